// File: doc/BRIEF.md
# Two-Level UART Receive Buffer

This block sits between a UART receive shift register and the register read path. Each time the shift register finishes a character, it hands over the data bits together with that character's framing and parity status. The block stores up to two such characters in arrival order. The status bits are kept with each character, so the error flags always describe the oldest unread one. Every access to the data location returns the oldest character and removes it. When both slots are full, one further finished character can wait in the shift register. It moves into the buffer in the same cycle that a read frees a slot.

An overrun is recorded when a new start bit is detected while the buffer is full and a character is already waiting. The overrun mark is attached to the next character that enters the buffer. Turning the receiver off discards everything: both slots, the waiting character and any pending overrun. The receive interrupt request is the receive-complete flag gated by its enable.

Top module: `uart_rx_fifo2`

## Requirements
- R1: The buffer holds at most two characters and returns them oldest first on `rd_data_o`. `rd_data_o` reads 0 when the buffer is empty.
- R2: Upper bits unused by the character length are stored as zero. `char_len_i` codes are 0 for 5 bits, 1 for 6 bits, 2 for 7 bits and 3 for 8 bits.
- R3: `rxc_o` is 1 exactly when the buffer holds at least one unread character.
- R4: While `rx_en_i` is 0, the clock edge empties the buffer, drops the waiting character and clears any pending overrun. Incoming characters are ignored, and `rxc_o` is 0 from the next cycle on.
- R5: `fe_o` and `pe_o` show the frame-error and parity-error status captured with the head character. They stay as they are until that character is read, and both are 0 when the buffer is empty.
- R6: A character that finishes while the buffer is full waits outside the buffer and enters it at the edge where a read frees a slot. If another character finishes before that, the newer character replaces the waiting one.
- R7: A start-bit strobe while the buffer is full and a character is waiting marks an overrun. The overrun mark goes with the next character pushed into the buffer. `dor_o` shows the mark of the head character.
- R8: Each `rd_i` pulse removes exactly one character when the buffer is not empty. A read of an empty buffer changes nothing.
- R9: `irq_o` equals `rxc_o` AND `rxc_ie_i`, with no register delay.
- R10: After reset the buffer is empty, there is no waiting character and all flags are 0.
- R11: When a read and a push happen in the same cycle on a full buffer, the buffer stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; low flushes the buffer |
| start_det_i | input | 1 | Start-bit detect strobe from the sampler |
| char_done_i | input | 1 | Character-finished strobe from the shift register |
| char_data_i | input | DATA_W | Received character bits |
| char_fe_i | input | 1 | First stop bit sampled as 0 |
| char_pe_i | input | 1 | Parity mismatch on this character |
| char_len_i | input | 2 | Character length code |
| rd_i | input | 1 | Access to the data location (pops) |
| rxc_ie_i | input | 1 | Receive interrupt enable |
| rd_data_o | output | DATA_W | Head character |
| rxc_o | output | 1 | Receive complete |
| fe_o | output | 1 | Frame error of head character |
| pe_o | output | 1 | Parity error of head character |
| dor_o | output | 1 | Overrun mark of head character |
| irq_o | output | 1 | Receive interrupt request |

## Verification
All buffer state changes at the clock edge where the strobe or read is sampled. The head data, the three flags and `rxc_o` are therefore due one edge after the stimulus. `irq_o` is combinational, so it follows `rxc_ie_i` in the same cycle. The bench drives inputs and advances its queue model at the falling edge. At the next falling edge, after the design's register update, it compares every output with the model, which places each check exactly one edge after its stimulus.

// File: rtl/uart_rx_fifo2.sv
module uart_rx_fifo2 #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              start_det_i,
  input  logic              char_done_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_fe_i,
  input  logic              char_pe_i,
  input  logic [1:0]        char_len_i,
  input  logic              rd_i,
  input  logic              rxc_ie_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rxc_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              dor_o,
  output logic              irq_o
);

  localparam int WW = DATA_W + 2;
  localparam int EW = DATA_W + 3;

  logic [EW-1:0] slot_q [2];
  logic          head_q;
  logic [1:0]    cnt_q;
  logic [WW-1:0] wait_q;
  logic          wait_vld_q;
  logic          pend_dor_q;

  logic [DATA_W-1:0] len_mask;
  logic [WW-1:0]     new_ent;
  logic [WW-1:0]     cand;
  logic              full, pop, push, ovr, load_wait;
  logic              tail;
  logic [EW-1:0]     head_ent;

  assign len_mask = ~({DATA_W{1'b1}} << (MIN_BITS + int'(char_len_i)));
  assign new_ent  = {char_pe_i, char_fe_i, char_data_i & len_mask};
  assign full     = (cnt_q == 2'd2);
  assign pop      = rx_en_i && rd_i && (cnt_q != 2'd0);
  assign cand     = wait_vld_q ? wait_q : new_ent;
  assign push     = rx_en_i && (wait_vld_q || char_done_i) && (!full || pop);
  assign ovr      = rx_en_i && start_det_i && full && wait_vld_q;
  assign load_wait = rx_en_i && char_done_i && (wait_vld_q || !push);
  assign tail     = head_q ^ cnt_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q[0]  <= '0;
      slot_q[1]  <= '0;
      head_q     <= 1'b0;
      cnt_q      <= 2'd0;
      wait_q     <= '0;
      wait_vld_q <= 1'b0;
      pend_dor_q <= 1'b0;
    end else if (!rx_en_i) begin
      head_q     <= 1'b0;
      cnt_q      <= 2'd0;
      wait_vld_q <= 1'b0;
      pend_dor_q <= 1'b0;
    end else begin
      if (push) slot_q[tail] <= {pend_dor_q, cand};
      if (pop)  head_q <= ~head_q;
      cnt_q <= cnt_q + {1'b0, push} - {1'b0, pop};
      if (load_wait) begin
        wait_q     <= new_ent;
        wait_vld_q <= 1'b1;
      end else if (push && wait_vld_q) begin
        wait_vld_q <= 1'b0;
      end
      pend_dor_q <= (pend_dor_q && !push) || ovr;
    end
  end

  assign head_ent  = slot_q[head_q];
  assign rxc_o     = (cnt_q != 2'd0);
  assign rd_data_o = rxc_o ? head_ent[DATA_W-1:0] : '0;
  assign fe_o      = rxc_o && head_ent[DATA_W];
  assign pe_o      = rxc_o && head_ent[DATA_W+1];
  assign dor_o     = rxc_o && head_ent[DATA_W+2];
  assign irq_o     = rxc_o && rxc_ie_i;

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 2'd2); // R1
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rxc_o); // R4
  AST_WAIT_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_vld_q |-> full); // R6
  AST_EMPTY_READ_NOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && rd_i && !rxc_o && !char_done_i && !wait_vld_q) |=> !rxc_o); // R8
  AST_FULL_SWAP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && full && rd_i && wait_vld_q) |=> full); // R11
  AST_IRQ_NEEDS_RXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rxc_o); // R9
  AST_HEAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && !rd_i && $past(rx_en_i) && rxc_o) |=> $stable(rd_data_o) && $stable(fe_o)); // R5

endmodule

// File: tb/uart_rx_fifo2_tb.sv
module uart_rx_fifo2_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sd = 1'b0, done = 1'b0, fe_in = 1'b0, pe_in = 1'b0, rd = 1'b0, ie = 1'b0;
  logic [DW-1:0] din = '0;
  logic [1:0] len = 2'd3;
  logic [DW-1:0] dout;
  logic rxc, fe, pe, dor, irq;

  int checks = 0;
  int fails = 0;
  string tag = "R10";

  logic [DW+2:0] q[$];
  logic [DW+1:0] wv;
  bit wvld = 0;
  bit pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_fifo2 #(.DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(en), .start_det_i(sd),
    .char_done_i(done), .char_data_i(din), .char_fe_i(fe_in), .char_pe_i(pe_in),
    .char_len_i(len), .rd_i(rd), .rxc_ie_i(ie), .rd_data_o(dout), .rxc_o(rxc),
    .fe_o(fe), .pe_o(pe), .dor_o(dor), .irq_o(irq)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [DW+2:0] h;
    bit ne;
    ne = (q.size() > 0);
    h = ne ? q[0] : '0;
    chk("R1 data", int'(dout), int'(h[DW-1:0]));
    chk("R3 rxc", int'(rxc), int'(ne));
    chk("R5 fe", int'(fe), int'(h[DW]));
    chk("R5 pe", int'(pe), int'(h[DW+1]));
    chk("R7 dor", int'(dor), int'(h[DW+2]));
    chk("R9 irq", int'(irq), int'(ne && ie));
  endtask

  task automatic model();
    logic [DW-1:0] m;
    bit ovr, pushed, used;
    if (!en) begin
      q.delete(); wvld = 0; pend = 0;
      return;
    end
    ovr = sd && q.size() == 2 && wvld;
    if (rd && q.size() > 0) void'(q.pop_front());
    m = '0;
    for (int b = 0; b < 5 + int'(len) && b < DW; b++) m[b] = din[b];
    pushed = 0; used = 0;
    if (wvld && q.size() < 2) begin
      q.push_back({pend, wv}); wvld = 0; pushed = 1;
    end else if (!wvld && done && q.size() < 2) begin
      q.push_back({pend, pe_in, fe_in, m}); pushed = 1; used = 1;
    end
    if (done && !used) begin
      wv = {pe_in, fe_in, m}; wvld = 1;
    end
    pend = (pushed ? 1'b0 : pend) | ovr;
  endtask

  task automatic step(bit e, bit s, bit d, logic [DW-1:0] v, bit f, bit p, logic [1:0] l, bit r, bit i);
    @(negedge clk);
    compare();
    en = e; sd = s; done = d; din = v; fe_in = f; pe_in = p; len = l; rd = r; ie = i;
    model();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R10";
    step(0, 0, 0, 0, 0, 0, 3, 0, 1);
    tag = "R2";
    step(1, 0, 1, 8'hFF, 1, 0, 0, 0, 1);
    step(1, 0, 1, 8'hFF, 0, 1, 1, 0, 1);
    step(1, 0, 1, 8'hFF, 0, 0, 2, 0, 1);
    tag = "R6";
    step(1, 1, 0, 0, 0, 0, 3, 0, 1);
    step(1, 0, 1, 8'hA5, 0, 0, 3, 0, 0);
    tag = "R11";
    step(1, 0, 0, 0, 0, 0, 3, 1, 0);
    step(1, 0, 0, 0, 0, 0, 3, 0, 0);
    tag = "R8";
    step(1, 0, 0, 0, 0, 0, 3, 1, 0);
    step(1, 0, 0, 0, 0, 0, 3, 1, 0);
    step(1, 0, 0, 0, 0, 0, 3, 1, 1);
    step(1, 0, 0, 0, 0, 0, 3, 0, 1);
    tag = "R7";
    step(1, 0, 1, 8'h11, 0, 0, 3, 0, 1);
    step(1, 0, 1, 8'h22, 1, 0, 3, 0, 1);
    step(1, 0, 1, 8'h33, 0, 1, 3, 0, 1);
    step(1, 1, 0, 0, 0, 0, 3, 0, 1);
    step(1, 0, 1, 8'h44, 0, 0, 3, 0, 1);
    step(1, 0, 0, 0, 0, 0, 3, 1, 1);
    step(1, 0, 0, 0, 0, 0, 3, 1, 1);
    step(1, 0, 0, 0, 0, 0, 3, 0, 1);
    tag = "R4";
    step(1, 0, 1, 8'h55, 0, 0, 3, 0, 1);
    step(0, 0, 1, 8'h66, 1, 1, 3, 0, 1);
    step(1, 0, 0, 0, 0, 0, 3, 0, 1);
    tag = "R1";
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 40) != 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
           DW'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
           2'($urandom), ($urandom % 3) == 0, ($urandom % 2) == 0);
    end
    step(1, 0, 0, 0, 0, 0, 3, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule